// File: doc/BRIEF.md
# Programmable Divider With Phase Offset

This block divides a fast input clock by a programmable ratio and presents the result as a registered output level. One output period has two parts. The output first stays high for a programmed number of input cycles. It then stays low for a second programmed number. Both counts come packed in one configuration byte, and each count is stored as the wanted number of cycles minus one.

The block can also hold back the first rising edge of its output by a coarse number of input cycles. Several copies of the block, fed from the same input clock and given different offsets, therefore produce outputs skewed by whole input cycles. The offset is built from a 4-bit offset field and a start-high bit. When the start-high bit is set, the delay also folds in the programmed low-cycle count.

A synchronisation strobe makes a new offset take effect. While the strobe is high, the output is held low and the counters are cleared. When the strobe is released, the block counts the delay and then begins its first high phase. Reset acts the same way as the strobe.

Top module: `phase_offset_divider`

## Requirements
- R1: `div_cfg` carries two fields. Bits [3:0] hold the high count H and bits [7:4] hold the low count L, each encoded as cycles minus one.
- R2: After the delay, the output is high for H+1 input cycles and then low for L+1 input cycles, repeating with period H+L+2. The high phase comes first.
- R3: The offset code is P = 16·`start_high` + `phase_ofs`, which ranges from 0 to 31.
- R4: For P from 0 to 15, the first rising edge comes P input cycles later than it would with P = 0.
- R5: For P from 16 to 31, the first rising edge is delayed by (P − 16) + L + 1 input cycles. L is the low count present during the last cycle that `sync_in` is high.
- R6: While `sync_in` is high, `div_out` is low. After `sync_in` falls, the output restarts from a cleared state, whatever phase it had before.
- R7: Changing `phase_ofs` or `start_high` while `sync_in` is low has no effect on `div_out`.
- R8: While `rst` is high, `div_out` is low. Releasing `rst` starts the output in the same way as releasing `sync_in`, using the offset that is configured at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| sync_in | input | 1 | Synchronisation strobe: holds the output low and captures the offset |
| div_cfg | input | 8 | Packed counts: [7:4] low cycles − 1, [3:0] high cycles − 1 |
| phase_ofs | input | 4 | Coarse phase offset field |
| start_high | input | 1 | Start-high bit, which selects the offset form that adds the low count |
| div_out | output | 1 | Divided clock, registered |

## Verification
Name the first clock edge that samples `sync_in` (or `rst`) low as edge 1. The output is registered, so its value after edge i is high exactly when k = i − 1 − D is not negative and k mod (H+L+2) < H+1, where D is the delay that R4 or R5 gives. The bench drives every input on the falling edge and reads `div_out` on the next falling edge after each rising edge. Each sample therefore lands one register stage after the edge that produced it, and the expected value comes from this formula alone. The first-edge delay, the duty cycle and the period are compared cycle by cycle for all 32 offset codes, each with several low counts. Checks on holding and ignoring inputs read the output during and after the changed stimulus.

// File: rtl/pod_pkg.sv
package pod_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HI   = 2'd2,
    ST_LO   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/pod_cfg_split.sv
module pod_cfg_split #(
  parameter int CNT_W = 4
) (
  input  logic [2*CNT_W-1:0] cfg_byte,
  output logic [CNT_W-1:0]   hi_cnt,
  output logic [CNT_W-1:0]   lo_cnt
);
  // upper field is the low-phase count, lower field the high-phase count
  always_comb begin
    hi_cnt = cfg_byte[CNT_W-1:0];
    lo_cnt = cfg_byte[2*CNT_W-1:CNT_W];
  end
endmodule

// File: rtl/pod_offset_calc.sv
module pod_offset_calc #(
  parameter int CNT_W = 4,
  parameter int OFS_W = 4,
  parameter int DLY_W = 5
) (
  input  logic [OFS_W-1:0] ofs,
  input  logic             sh,
  input  logic [CNT_W-1:0] lo_cnt,
  output logic [DLY_W-1:0] delay
);
  // without start-high the code is used directly; with it the upper code
  // range maps to the offset field plus one full low phase
  always_comb begin
    if (sh)
      delay = DLY_W'(ofs) + DLY_W'(lo_cnt) + DLY_W'(1);
    else
      delay = DLY_W'(ofs);
  end
endmodule

// File: rtl/pod_seq.sv
module pod_seq
  import pod_pkg::*;
#(
  parameter int CNT_W = 4,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic [CNT_W-1:0] hi_i,
  input  logic [CNT_W-1:0] lo_i,
  output logic             out_o
);
  localparam int CW = (DLY_W > CNT_W) ? DLY_W : CNT_W;

  seq_state_t    st_q;
  logic [CW-1:0] cnt_q;
  logic          out_q;

  always_ff @(posedge clk) begin
    if (rst || hold_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      out_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (delay_i == '0) begin
            st_q  <= ST_HI;
            cnt_q <= CW'(hi_i);
            out_q <= 1'b1;
          end else begin
            st_q  <= ST_WAIT;
            cnt_q <= CW'(delay_i - DLY_W'(1));
          end
        end
        ST_WAIT: begin
          if (cnt_q == '0) begin
            st_q  <= ST_HI;
            cnt_q <= CW'(hi_i);
            out_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        ST_HI: begin
          if (cnt_q == '0) begin
            st_q  <= ST_LO;
            cnt_q <= CW'(lo_i);
            out_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
        default: begin
          if (cnt_q == '0) begin
            st_q  <= ST_HI;
            cnt_q <= CW'(hi_i);
            out_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - CW'(1);
          end
        end
      endcase
    end
  end

  assign out_o = out_q;

  // run-length of the high level, used only by the checks below
  logic [CNT_W+1:0] hi_run_q;
  always_ff @(posedge clk) begin
    if (rst)
      hi_run_q <= '0;
    else if (out_q)
      hi_run_q <= hi_run_q + 1'b1;
    else
      hi_run_q <= '0;
  end

  // R6: strobe forces the output low on the following cycle
  a_r6_hold_forces_low: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> !out_o);

  // R4: output stays low while the offset is still being counted
  a_r4_wait_is_low: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_WAIT) |-> !out_o);

  // R2: a high phase never outlasts the largest programmable count
  a_r2_high_bounded: assert property (@(posedge clk) disable iff (rst)
    hi_run_q <= (CNT_W+2)'(1 << CNT_W));

  // R2: a high phase always ends in the low phase, never in waiting
  a_r2_fall_to_low: assert property (@(posedge clk) disable iff (rst)
    (!hold_i && $fell(out_o)) |-> (st_q == ST_LO));
endmodule

// File: rtl/phase_offset_divider.sv
module phase_offset_divider #(
  parameter int CNT_W = 4,
  parameter int OFS_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sync_in,
  input  logic [2*CNT_W-1:0] div_cfg,
  input  logic [OFS_W-1:0]   phase_ofs,
  input  logic               start_high,
  output logic               div_out
);
  localparam int DLY_W = ((OFS_W > CNT_W) ? OFS_W : CNT_W) + 1;

  logic [CNT_W-1:0] hi_cnt, lo_cnt;
  logic [DLY_W-1:0] delay_calc;
  logic [DLY_W-1:0] delay_q;
  logic             hold;

  assign hold = sync_in;

  pod_cfg_split #(.CNT_W(CNT_W)) split_i (
    .cfg_byte (div_cfg),
    .hi_cnt   (hi_cnt),
    .lo_cnt   (lo_cnt)
  );

  pod_offset_calc #(.CNT_W(CNT_W), .OFS_W(OFS_W), .DLY_W(DLY_W)) calc_i (
    .ofs    (phase_ofs),
    .sh     (start_high),
    .lo_cnt (lo_cnt),
    .delay  (delay_calc)
  );

  // offset is captured only while reset or the strobe is active
  always_ff @(posedge clk) begin
    if (rst || sync_in)
      delay_q <= delay_calc;
  end

  pod_seq #(.CNT_W(CNT_W), .DLY_W(DLY_W)) seq_i (
    .clk     (clk),
    .rst     (rst),
    .hold_i  (hold),
    .delay_i (delay_q),
    .hi_i    (hi_cnt),
    .lo_i    (lo_cnt),
    .out_o   (div_out)
  );

  // R7: captured offset cannot move while the strobe is low
  a_r7_offset_frozen: assert property (@(posedge clk) disable iff (rst)
    (!sync_in && !$past(sync_in)) |-> $stable(delay_q));
endmodule

// File: tb/phase_offset_divider_tb_top.sv
module phase_offset_divider_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sync_in = 1'b0;
  logic [7:0] div_cfg = 8'h00;
  logic [3:0] phase_ofs = 4'h0;
  logic       start_high = 1'b0;
  logic       div_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  phase_offset_divider dut_i (
    .clk        (clk),
    .rst        (rst),
    .sync_in    (sync_in),
    .div_cfg    (div_cfg),
    .phase_ofs  (phase_ofs),
    .start_high (start_high),
    .div_out    (div_out)
  );

  function automatic int dly_of(int ofs, bit sh, int lo);
    return sh ? (ofs + lo + 1) : ofs;   // R3 R4 R5
  endfunction

  function automatic bit exp_of(int i, int d, int hi, int lo);
    int k = i - 1 - d;
    if (k < 0) return 1'b0;
    return ((k % (hi + lo + 2)) < (hi + 1)) ? 1'b1 : 1'b0;
  endfunction

  task automatic chk(string req, bit act, bit exp, int cyc);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: div_out=%b expected %b", req, cyc, act, exp);
    end
  endtask

  // strobe for two cycles with the given setup, then release
  task automatic do_sync(int hi, int lo, int ofs, bit sh);
    @(negedge clk);
    div_cfg = {4'(lo), 4'(hi)};
    phase_ofs = 4'(ofs);
    start_high = sh;
    sync_in = 1'b1;
    for (int j = 0; j < 2; j++) begin
      @(negedge clk);
      chk("R6", div_out, 1'b0, -1);
    end
    sync_in = 1'b0;
  endtask

  task automatic run_case(string req, int hi, int lo, int ofs, bit sh);
    int d = dly_of(ofs, sh, lo);
    int len = d + 2 * (hi + lo + 2) + 2;
    do_sync(hi, lo, ofs, sh);
    for (int i = 1; i <= len; i++) begin
      @(negedge clk);
      chk(req, div_out, exp_of(i, d, hi, lo), i);
    end
  endtask

  task automatic t_reset();
    // R8: low during reset, then start from the offset set before release
    div_cfg = {4'd2, 4'd1};
    phase_ofs = 4'd3;
    start_high = 1'b0;
    rst = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      chk("R8", div_out, 1'b0, -1);
    end
    rst = 1'b0;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      chk("R8", div_out, exp_of(i, 3, 1, 2), i);
    end
  endtask

  task automatic t_sweep();
    // R3 R4 R5 R2: every offset code with several low counts
    int lows[3] = '{0, 3, 15};
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 32; p++)
        run_case((p < 16) ? "R4" : "R5", (p + m) % 5, lows[m], p % 16, p >= 16);
  endtask

  task automatic t_packing();
    // R1 R2: asymmetric fields expose swapped or mis-encoded nibbles
    run_case("R1", 0, 6, 0, 1'b0);
    run_case("R1", 9, 1, 2, 1'b0);
    run_case("R2", 15, 15, 0, 1'b0);
    run_case("R2", 0, 0, 0, 1'b0);
  endtask

  task automatic t_ofs_no_sync();
    // R7: change offset mid-run without a strobe; pattern must not move
    int d = dly_of(2, 1'b0, 3);
    do_sync(2, 3, 2, 1'b0);
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      chk("R7", div_out, exp_of(i, d, 2, 3), i);
      if (i == 10) begin
        phase_ofs = 4'd9;
        start_high = 1'b1;
      end
    end
  endtask

  task automatic t_resync();
    // R6: strobe mid-phase, output realigns from release
    do_sync(3, 3, 0, 1'b0);
    for (int i = 1; i <= 5; i++) @(negedge clk);
    run_case("R6", 3, 3, 5, 1'b0);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_packing();
    t_ofs_no_sync();
    t_resync();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule